// File: doc/BRIEF.md
# Interrupt and Exception Entry Controller

This block sits next to a simple CPU core and decides, cycle by cycle, whether the core must leave its current instruction stream. It arbitrates between four kinds of event: a reset request, a return-from-handler strobe, a non-maskable interrupt (NMI) and six level-held maskable interrupt requests. For the event it accepts, it saves the context into its own save registers, updates its cause register and gives the core both a new status word and a redirect target PC in the same cycle. The core owns the PC and the status word. It presents them on `cur_pc` and `cur_psw`, and it loads `redirect_pc` and `psw_next` at the next clock edge whenever `redirect` and `psw_wr` are high.

Three status bits matter to the block: bit 7 (NMI in progress), bit 6 (exception pending) and bit 5 (interrupt disable). Every other status bit passes through an entry unchanged. An NMI that cannot be taken is remembered in a single pending flag. A maskable requester holds its line until it sees its acknowledge pulse.

Top module: `irq_entry_ctrl`

## Requirements
- R1: `reset_req` wins over every other input. In that cycle the block drives `redirect`=1, `redirect_pc`=0, `psw_wr`=1 and `psw_next`=0x20 with no acknowledge. From the next cycle `cause` reads 0 and any remembered NMI is discarded.
- R2: When `reset_req` is low, `ret_req` wins over NMI and maskable requests. The block redirects to `nmi_save_pc` and writes `nmi_save_psw` if bit 7 of `cur_psw` is set; otherwise it uses `irq_save_pc` and `irq_save_psw`. An NMI that arrives in that cycle is remembered.
- R3: An NMI (new or remembered) is taken when bit 7 of `cur_psw` is clear. The block redirects to 0x10 with `psw_next` equal to `cur_psw` with bits 7 and 5 set and bit 6 cleared. From the next cycle `nmi_save_pc` and `nmi_save_psw` hold the pre-entry PC and status, `cause[31:16]` is 0, and `cause[15:0]` is its old value ORed with 0x10.
- R4: An NMI seen while bit 7 is set is not taken. One such NMI is remembered and further ones are dropped. The remembered NMI is taken in the first cycle in which bit 7 is clear and no reset or return is present.
- R5: If a new NMI arrives in the cycle a remembered NMI is taken, one NMI is delivered and one stays remembered for a later entry.
- R6: No maskable request is taken while bit 7 or bit 5 of `cur_psw` is set, or while an NMI is present. Such a request gets no acknowledge and is retried every cycle it stays asserted.
- R7: Taking maskable source i (0..5) redirects to 0x80+0x10*i with `psw_next` equal to `cur_psw` with bit 5 set and bit 6 cleared. From the next cycle `irq_save_pc` and `irq_save_psw` hold the pre-entry PC and status, `cause[15:0]` equals the vector and `cause[31:16]` is unchanged.
- R8: Among simultaneous maskable requests the lowest index wins. `irq_ack` is one-hot for that source in the entry cycle only and zero in every other cycle.
- R9: While `rst_n` is low, and in the first cycle after it, `cause` and all four save registers read 0 and no NMI is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low register reset |
| reset_req | input | 1 | Reset event request |
| nmi_req | input | 1 | NMI pulse |
| irq_req | input | 6 | Level-held maskable requests |
| ret_req | input | 1 | Return-from-handler strobe |
| cur_pc | input | 32 | Core's current PC |
| cur_psw | input | 32 | Core's current status word |
| redirect | output | 1 | Core must load `redirect_pc` |
| redirect_pc | output | 32 | Redirect target |
| psw_wr | output | 1 | Core must load `psw_next` |
| psw_next | output | 32 | New status word |
| cause | output | 32 | Cause register |
| nmi_save_pc | output | 32 | PC saved on NMI entry |
| nmi_save_psw | output | 32 | Status saved on NMI entry |
| irq_save_pc | output | 32 | PC saved on maskable entry |
| irq_save_psw | output | 32 | Status saved on maskable entry |
| irq_ack | output | 6 | One-hot acknowledge to the chosen requester |

## Verification
The collision that matters most is an NMI meeting a return strobe, or a new NMI meeting the delivery of a remembered one. Either way one NMI must be taken or deferred, and none may be lost or duplicated. The bench provokes both on purpose: it raises a second NMI inside an NMI handler and then pulses `nmi_req` together with `ret_req`. It also pulses a new NMI in the cycle a remembered one fires. A behavioural model that tracks the pending flag, core PC and status predicts every redirect, and it is compared with the block on every cycle, alongside a long random mix of all inputs.

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int NIRQ   = 6,
  parameter int XLEN   = 32,
  parameter int NP_BIT = 7,
  parameter int EP_BIT = 6,
  parameter int ID_BIT = 5,
  parameter logic [31:0] NMI_VEC   = 32'h10,
  parameter logic [31:0] IRQ_VEC0  = 32'h80,
  parameter logic [31:0] IRQ_STEP  = 32'h10,
  parameter logic [31:0] RESET_PSW = 32'h20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reset_req,
  input  logic            nmi_req,
  input  logic [NIRQ-1:0] irq_req,
  input  logic            ret_req,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_psw,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic            psw_wr,
  output logic [XLEN-1:0] psw_next,
  output logic [XLEN-1:0] cause,
  output logic [XLEN-1:0] nmi_save_pc,
  output logic [XLEN-1:0] nmi_save_psw,
  output logic [XLEN-1:0] irq_save_pc,
  output logic [XLEN-1:0] irq_save_psw,
  output logic [NIRQ-1:0] irq_ack
);
  localparam int SELW = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam int HALF = XLEN / 2;

  logic            nmi_pend;
  logic [SELW-1:0] sel;
  logic            sel_v;

  wire np       = cur_psw[NP_BIT];
  wire id       = cur_psw[ID_BIT];
  wire nmi_any  = nmi_req | nmi_pend;
  wire take_ret = !reset_req && ret_req;
  wire take_nmi = !reset_req && !ret_req && nmi_any && !np;
  wire take_irq = !reset_req && !ret_req && !nmi_any && !np && !id && sel_v;

  wire [XLEN-1:0] irq_vec = XLEN'(IRQ_VEC0) + XLEN'(IRQ_STEP) * XLEN'(sel);
  wire [XLEN-1:0] np_m = XLEN'(1) << NP_BIT;
  wire [XLEN-1:0] ep_m = XLEN'(1) << EP_BIT;
  wire [XLEN-1:0] id_m = XLEN'(1) << ID_BIT;

  always_comb begin
    sel   = '0;
    sel_v = 1'b0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (irq_req[i]) begin
        sel   = SELW'(i);
        sel_v = 1'b1;
      end
  end

  assign redirect = reset_req | take_ret | take_nmi | take_irq;
  assign psw_wr   = redirect;
  assign irq_ack  = take_irq ? (NIRQ'(1) << sel) : '0;

  always_comb begin
    redirect_pc = '0;
    psw_next    = cur_psw;
    if (reset_req) begin
      psw_next = XLEN'(RESET_PSW);
    end else if (take_ret) begin
      redirect_pc = np ? nmi_save_pc  : irq_save_pc;
      psw_next    = np ? nmi_save_psw : irq_save_psw;
    end else if (take_nmi) begin
      redirect_pc = XLEN'(NMI_VEC);
      psw_next    = (cur_psw | np_m | id_m) & ~ep_m;
    end else if (take_irq) begin
      redirect_pc = irq_vec;
      psw_next    = (cur_psw | id_m) & ~ep_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_pend     <= 1'b0;
      cause        <= '0;
      nmi_save_pc  <= '0;
      nmi_save_psw <= '0;
      irq_save_pc  <= '0;
      irq_save_psw <= '0;
    end else if (reset_req) begin
      nmi_pend <= 1'b0;
      cause    <= '0;
    end else if (take_nmi) begin
      nmi_pend     <= nmi_req & nmi_pend;
      nmi_save_pc  <= cur_pc;
      nmi_save_psw <= cur_psw;
      cause        <= {{(XLEN-HALF){1'b0}}, cause[HALF-1:0] | HALF'(NMI_VEC)};
    end else begin
      nmi_pend <= nmi_pend | nmi_req;
      if (take_irq) begin
        irq_save_pc  <= cur_pc;
        irq_save_psw <= cur_psw;
        cause        <= {cause[XLEN-1:HALF], irq_vec[HALF-1:0]};
      end
    end
  end

  // R8: at most one requester acknowledged
  a_r8_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));

  // R6: masked status never yields an acknowledge
  a_r6_masked_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (np || id) |-> (irq_ack == '0));

  // R4: with NMI in progress only reset or return may redirect
  a_r4_np_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (np && !reset_req && !ret_req) |-> !redirect);

  // R1: reset clears the cause register
  a_r1_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (cause == '0));

  // R3: NMI entry saves status and clears upper cause half
  a_r3_nmi_save: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |=> (nmi_save_psw == $past(cur_psw)) && (cause[XLEN-1:HALF] == '0)
                 && (nmi_save_pc == $past(cur_pc)));

  // R7: maskable entry saves PC and loads vector into cause
  a_r7_irq_save: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |=> (irq_save_pc == $past(cur_pc))
                   && (cause[HALF-1:0] == $past(redirect_pc[HALF-1:0])));
endmodule

// File: tb/test_irq_entry_ctrl.sv
`timescale 1ns/1ps
module test_irq_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_req = 1'b0, nmi_req = 1'b0, ret_req = 1'b0;
  logic [5:0]  irq_req = '0;
  logic [31:0] cur_pc = '0, cur_psw = '0;
  logic        redirect, psw_wr;
  logic [31:0] redirect_pc, psw_next, cause;
  logic [31:0] nmi_save_pc, nmi_save_psw, irq_save_pc, irq_save_psw;
  logic [5:0]  irq_ack;

  always #4 clk = ~clk;

  irq_entry_ctrl i_irq_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_req(nmi_req),
    .irq_req(irq_req), .ret_req(ret_req), .cur_pc(cur_pc), .cur_psw(cur_psw),
    .redirect(redirect), .redirect_pc(redirect_pc), .psw_wr(psw_wr),
    .psw_next(psw_next), .cause(cause), .nmi_save_pc(nmi_save_pc),
    .nmi_save_psw(nmi_save_psw), .irq_save_pc(irq_save_pc),
    .irq_save_psw(irq_save_psw), .irq_ack(irq_ack));

  int checks = 0, fails = 0;
  bit done = 0;
  string ctx = "R9";

  // model state
  logic [31:0] m_pc, m_psw, m_cause, m_npc, m_npsw, m_ipc, m_ipsw;
  bit m_pend;
  logic [5:0] lvl;
  // predictions
  bit e_red; logic [31:0] e_pc, e_psw; logic [5:0] e_ack;
  string act; int e_kind; int e_src;
  int nmi_entries;

  task automatic chk(string name, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (%s) %s: got %h expected %h", ctx, act, name, got, exp);
    end
  endtask

  task automatic predict(bit rr, bit nm, bit rt);
    bit any = nm || m_pend;
    bit np = m_psw[7], id = m_psw[5];
    e_src = -1;
    for (int i = 5; i >= 0; i--) if (lvl[i]) e_src = i;
    e_red = 1; e_ack = '0; e_pc = 0; e_psw = m_psw;
    if (rr) begin e_kind = 1; act = "R1"; e_psw = 32'h20; end
    else if (rt) begin
      e_kind = 2; act = "R2";
      e_pc = np ? m_npc : m_ipc; e_psw = np ? m_npsw : m_ipsw;
    end else if (any && !np) begin
      e_kind = 3; act = "R3"; e_pc = 32'h10;
      e_psw = (m_psw | 32'h80 | 32'h20) & ~32'h40;
    end else if (!any && !np && !id && e_src >= 0) begin
      e_kind = 4; act = "R7"; e_pc = 32'h80 + 32'h10 * e_src;
      e_psw = (m_psw | 32'h20) & ~32'h40; e_ack[e_src] = 1'b1;
    end else begin e_kind = 0; act = "R6"; e_red = 0; end
  endtask

  task automatic commit(bit nm);
    case (e_kind)
      1: begin m_cause = 0; m_pend = 0; end
      2: m_pend = m_pend | nm;
      3: begin
        m_npc = m_pc; m_npsw = m_psw;
        m_cause = (m_cause & 32'hffff) | 32'h10;
        m_pend = nm && m_pend; nmi_entries++;
      end
      4: begin
        m_ipc = m_pc; m_ipsw = m_psw;
        m_cause = (m_cause & 32'hffff0000) | e_pc;
        lvl[e_src] = 1'b0;
      end
      default: m_pend = m_pend | nm;
    endcase
    if (e_kind == 4 || e_kind == 0) m_pend = m_pend | (e_kind == 0 ? 1'b0 : 1'b0);
    m_pc  = e_red ? e_pc : m_pc + 4;
    m_psw = e_psw;
  endtask

  task automatic cyc(bit rr, bit nm, bit rt);
    reset_req = rr; nmi_req = nm; ret_req = rt;
    irq_req = lvl; cur_pc = m_pc; cur_psw = m_psw;
    #1;
    predict(rr, nm, rt);
    chk("redirect", 32'(redirect), 32'(e_red));
    chk("psw_wr", 32'(psw_wr), 32'(e_red));
    if (e_red) begin
      chk("redirect_pc", redirect_pc, e_pc);
      chk("psw_next", psw_next, e_psw);
    end
    chk("R8 irq_ack", 32'(irq_ack), 32'(e_ack));
    chk("cause", cause, m_cause);
    chk("nmi_save_pc", nmi_save_pc, m_npc);
    chk("nmi_save_psw", nmi_save_psw, m_npsw);
    chk("irq_save_pc", irq_save_pc, m_ipc);
    chk("irq_save_psw", irq_save_psw, m_ipsw);
    @(posedge clk);
    commit(nm);
    @(negedge clk);
  endtask

  initial begin
    m_pc = 32'h1000; m_psw = 0; m_cause = 0; m_npc = 0; m_npsw = 0;
    m_ipc = 0; m_ipsw = 0; m_pend = 0; lvl = '0; nmi_entries = 0;
    repeat (3) @(negedge clk);
    // R9: register reset state
    ctx = "R9";
    chk("cause at reset", cause, 0);
    chk("nmi_save_pc at reset", nmi_save_pc, 0);
    chk("irq_save_psw at reset", irq_save_psw, 0);
    rst_n = 1'b1;
    cyc(0, 0, 0);
    // R1: reset event
    ctx = "R1"; m_psw = 32'hffff_0f0f; cyc(1, 0, 0);
    chk("R1 psw after reset", m_psw, 32'h20);
    // R6: ID set from reset blocks maskable source 2
    ctx = "R6"; lvl[2] = 1;
    repeat (3) cyc(0, 0, 0);
    // R7: enable and take source 2 (vector 0xA0)
    ctx = "R7"; m_psw = 32'h0000_0041; cyc(0, 0, 0); cyc(0, 0, 0);
    // R2 + R8: return then two sources at once
    ctx = "R8"; lvl[0] = 1; lvl[5] = 1; cyc(0, 0, 1);
    cyc(0, 0, 0); cyc(0, 0, 0);
    ctx = "R2"; cyc(0, 0, 1); cyc(0, 0, 0);
    // R3: NMI inside a maskable handler
    ctx = "R3"; lvl[3] = 1; cyc(0, 1, 0); cyc(0, 0, 0);
    // R4: two NMIs while NP set, only one remembered
    ctx = "R4"; cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 0, 0);
    nmi_entries = 0;
    m_psw = m_psw & ~32'h80; cyc(0, 0, 0);
    m_psw = m_psw & ~32'h80; cyc(0, 0, 0);
    chk("R4 exactly one deferred NMI", nmi_entries, 1);
    // R2: return coinciding with NMI defers it
    ctx = "R2"; nmi_entries = 0; cyc(0, 1, 1);
    chk("R2 NMI not taken with return", nmi_entries, 0);
    cyc(0, 0, 0);
    chk("R2 deferred NMI taken after return", nmi_entries, 1);
    // R5: new NMI as remembered one fires
    ctx = "R5"; cyc(0, 1, 0);
    nmi_entries = 0;
    m_psw = m_psw & ~32'h80; cyc(0, 1, 0);
    m_psw = m_psw & ~32'h80; cyc(0, 0, 0);
    m_psw = m_psw & ~32'h80; cyc(0, 0, 0);
    chk("R5 two NMI entries", nmi_entries, 2);
    // R1: reset with NMI pending discards it
    ctx = "R1"; cyc(0, 1, 0); cyc(1, 1, 0);
    nmi_entries = 0; m_psw = 0; cyc(0, 0, 0);
    chk("R1 pending discarded", nmi_entries, 0);
    // mixed random traffic
    ctx = "R6";
    for (int n = 0; n < 4000; n++) begin
      bit rr = ($urandom_range(0, 199) == 0);
      bit nm = ($urandom_range(0, 15) == 0);
      bit rt = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 9) == 0) lvl[$urandom_range(0, 5)] = 1'b1;
      if ($urandom_range(0, 19) == 0) m_psw = m_psw & ~32'h20;
      if ($urandom_range(0, 29) == 0) m_psw = m_psw & ~32'h80;
      cyc(rr, nm, rt);
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule